// File: doc/BRIEF.md
# Prioritised Interrupt Flag Controller

This block sits next to a small processor core and decides which interrupt, if any, the core should take. Each edge-type source delivers a one-cycle event strobe. The strobe sets a sticky flag, whatever the state of the enables. Each source also has an enable bit, held in one of two mask registers: a general external-interrupt mask covering sources 0 to 7, and a timer mask covering sources 8 to 15. A single global enable gates every request to the core.

Sources picked by the `LEVEL_SRC` parameter have no flag. Such a source requests service only while its input is high. When at least one source is both pending and enabled and the global enable is set, the block raises a request and presents the lowest pending vector index. The core pulses `ack` at the moment it takes the vector. The block then clears that source's flag and drops the global enable. A `reti` pulse restores the global enable. Software may also write the global enable inside a handler to allow nesting.

Software accesses the block through a small write/read port. The flags of sources picked by `W1C_SRC` can be cleared by writing ones to them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, both mask registers, all flags and the global enable read as zero, and `irq_req` is low.
- R2: A strobe on an edge source sets its flag on the next clock edge, whether or not its mask bit or the global enable is set. The flag reads back at address 2 (sources 0-7, bit i = source i) or address 3 (sources 8-15, bit i = source 8+i).
- R3: `irq_req` is high exactly when the global enable is set and some source is both pending and enabled. Writes to address 0 set the external mask (bit i = source i). Writes to address 1 set the timer mask (bit i = source 8+i).
- R4: While `irq_req` is high, `irq_vec` is the lowest index among the pending, enabled sources.
- R5: An `ack` while `irq_req` is high clears the flag of the presented vector and clears the global enable on the next edge.
- R6: A `reti` pulse sets the global enable. Writing address 4 loads bit 0 into the global enable, which reads back at address 4 bit 0. An accepted `ack` overrides both, and `reti` overrides a same-cycle write.
- R7: Writing ones to address 2 or 3 clears the matching flags only for sources in `W1C_SRC` (default: sources 8-15). Zero bits, and sources outside that set, are left unchanged.
- R8: A strobe arriving in the same cycle as a hardware or software clear of its flag leaves the flag set.
- R9: A level source (default: source 0) never sets a flag and reads 0 in the flag register. It requests only while its input is high and it is enabled.
- R10: An `ack` while `irq_req` is low changes neither the flags nor the global enable.
- R11: Flags held while the global enable is clear are presented one after another in ascending index order as each is acknowledged and returned from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 ext mask, 1 timer mask, 2/3 flag clear, 4 global enable |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| src_in | input | 16 | Event strobes (edge sources) or request levels (level sources) |
| ack | input | 1 | Core is taking the presented vector |
| reti | input | 1 | Return-from-interrupt event |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 4 | Vector index of the presented source |
| gie | output | 1 | Global enable state |

## Verification
A flag that is wrongly stored shows up at the next edge in the flag read-back. When that source is enabled and the global enable is set, it also shows as a wrong `irq_req` or `irq_vec` in the same cycle. A lost global-enable update appears one cycle after `ack` or `reti`: requests stay up when they should drop, or stay masked when they should return. Collisions between a strobe and a clear are driven on purpose, because a dropped event would stay hidden until the next time the source is enabled.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int MASK_W = 8,
  parameter logic [2*MASK_W-1:0] LEVEL_SRC = 16'h0001,
  parameter logic [2*MASK_W-1:0] W1C_SRC   = 16'hFF00
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_addr,
  input  logic [MASK_W-1:0]             wr_data,
  input  logic [2:0]                    rd_addr,
  output logic [MASK_W-1:0]             rd_data,
  input  logic [2*MASK_W-1:0]           src_in,
  input  logic                          ack,
  input  logic                          reti,
  output logic                          irq_req,
  output logic [$clog2(2*MASK_W)-1:0]   irq_vec,
  output logic                          gie
);

  localparam int NSRC  = 2 * MASK_W;
  localparam int VEC_W = $clog2(NSRC);

  logic [MASK_W-1:0] ext_mask, tmr_mask;
  logic [NSRC-1:0]   flag, flag_d, enable, pend, evt, hw_clr, sw_clr;
  logic              take, gie_wr, gie_d;

  assign enable = {tmr_mask, ext_mask};
  assign evt    = src_in & ~LEVEL_SRC;
  assign pend   = (flag | (src_in & LEVEL_SRC)) & enable;

  always_comb begin
    irq_vec = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) irq_vec = VEC_W'(i);
  end

  assign irq_req = gie && (|pend);
  assign take    = ack && irq_req;
  assign gie_wr  = wr_en && (wr_addr == 3'd4);

  always_comb begin
    hw_clr = '0;
    if (take) hw_clr[irq_vec] = 1'b1;
  end

  assign sw_clr = {(wr_en && wr_addr == 3'd3) ? wr_data : {MASK_W{1'b0}},
                   (wr_en && wr_addr == 3'd2) ? wr_data : {MASK_W{1'b0}}} & W1C_SRC;

  assign flag_d = ((flag & ~(hw_clr | sw_clr)) | evt) & ~LEVEL_SRC;

  always_comb begin
    if (take)        gie_d = 1'b0;
    else if (reti)   gie_d = 1'b1;
    else if (gie_wr) gie_d = wr_data[0];
    else             gie_d = gie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_mask <= '0;
      tmr_mask <= '0;
      flag     <= '0;
      gie      <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 3'd0) ext_mask <= wr_data;
      if (wr_en && wr_addr == 3'd1) tmr_mask <= wr_data;
      flag <= flag_d;
      gie  <= gie_d;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = ext_mask;
      3'd1:    rd_data = tmr_mask;
      3'd2:    rd_data = flag[MASK_W-1:0];
      3'd3:    rd_data = flag[NSRC-1:MASK_W];
      3'd4:    rd_data = {{(MASK_W-1){1'b0}}, gie};
      default: rd_data = '0;
    endcase
  end

  a_r3_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie);

  a_r4_vec_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend[irq_vec]);

  a_r5_ack_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);

  a_r5_ack_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !src_in[irq_vec]) |=> !flag[$past(irq_vec)]);

  a_r6_reti_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take) |=> gie);

  a_r10_gie_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !reti && !gie_wr) |=> $stable(gie));

  for (genvar g = 0; g < NSRC; g++) begin : g_evt_chk
    if (!LEVEL_SRC[g]) begin : g_edge
      a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        src_in[g] |=> flag[g]);
    end else begin : g_lvl
      a_r9_no_level_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !flag[g]);
    end
  end

endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, ack = 0, reti = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [7:0]  wr_data = 0, rd_data;
  logic [15:0] src_in = 0;
  logic        irq_req, gie;
  logic [3:0]  irq_vec;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_in(src_in), .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .gie(gie));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    wr_en = 0; ack = 0; reti = 0;
    src_in = src_in & 16'h0001;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick();
  endtask

  task automatic rd(logic [2:0] a, output int v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic clean();
    src_in = 0;
    wr(0, 8'hFF); wr(1, 8'hFF); wr(4, 8'h01);
    for (int k = 0; k < 20 && irq_req; k++) begin
      ack = 1; tick(); reti = 1; tick();
    end
    wr(4, 0); wr(0, 0); wr(1, 0);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reg", v, 0);
    end
    chk("R1 irq_req", irq_req, 0);
  endtask

  task automatic t_latch_and_gate();
    int v;
    clean();
    src_in[3] = 1; tick();
    rd(2, v); chk("R2 flag latched while masked", v, 8'h08);
    chk("R3 no req when masked", irq_req, 0);
    wr(0, 8'h08);
    chk("R3 no req with gie clear", irq_req, 0);
    wr(4, 1);
    chk("R3 req", irq_req, 1);
    chk("R4 vec", irq_vec, 3);
  endtask

  task automatic t_priority_order();
    int v;
    wr(4, 0);
    src_in[10] = 1; src_in[5] = 1; tick();
    wr(0, 8'h28); wr(1, 8'h04); wr(4, 1);
    chk("R4 lowest wins", irq_vec, 3);
    ack = 1; tick();
    rd(2, v); chk("R5 flag cleared", v, 8'h20);
    chk("R5 gie cleared", gie, 0);
    chk("R5 req dropped", irq_req, 0);
    reti = 1; tick();
    chk("R6 reti sets gie", gie, 1);
    chk("R11 next vec", irq_vec, 5);
    ack = 1; tick(); reti = 1; tick();
    chk("R11 third vec", irq_vec, 10);
    ack = 1; tick(); reti = 1; tick();
    chk("R11 all served", irq_req, 0);
    rd(3, v); chk("R11 flags hi empty", v, 0);
  endtask

  task automatic t_w1c();
    int v;
    clean();
    src_in[9] = 1; src_in[12] = 1; src_in[2] = 1; tick();
    wr(3, 8'h02);
    rd(3, v); chk("R7 w1c hi", v, 8'h10);
    wr(2, 8'h04);
    rd(2, v); chk("R7 non-w1c kept", v, 8'h04);
    wr(3, 8'h00);
    rd(3, v); chk("R7 zero write", v, 8'h10);
  endtask

  task automatic t_collision();
    int v;
    wr_en = 1; wr_addr = 3; wr_data = 8'h10; src_in[12] = 1; tick();
    rd(3, v); chk("R8 sw clear vs event", v, 8'h10);
    wr(0, 8'h00); wr(1, 8'h10); wr(4, 1);
    chk("R8 vec 12", irq_vec, 12);
    ack = 1; src_in[12] = 1; tick();
    rd(3, v); chk("R8 ack clear vs event", v, 8'h10);
    chk("R8 gie cleared", gie, 0);
  endtask

  task automatic t_level();
    int v;
    clean();
    wr(0, 8'h01); wr(4, 1);
    src_in[0] = 1; #1;
    chk("R9 level req", irq_req, 1);
    chk("R9 level vec", irq_vec, 0);
    tick();
    rd(2, v); chk("R9 no level flag", v, 0);
    src_in[0] = 0; #1;
    chk("R9 level gone", irq_req, 0);
  endtask

  task automatic t_stray_ack();
    int v;
    src_in[4] = 1; tick();
    chk("R10 pre req", irq_req, 0);
    ack = 1; tick();
    rd(4, v); chk("R10 gie kept", v, 1);
    rd(2, v); chk("R10 flag kept", v, 8'h10);
    wr_en = 1; wr_addr = 4; wr_data = 0; reti = 1; tick();
    chk("R6 reti beats write", gie, 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #45 rst_n = 1; #2;
    t_reset();
    t_latch_and_gate();
    t_priority_order();
    t_w1c();
    t_collision();
    t_level();
    t_stray_ack();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule